// File: doc/BRIEF.md
# Static RAM Write Sequencer

This block performs one write to an asynchronous static RAM each time a host asks for one. The host offers an address and a data word on a valid/ready handshake. The block then drives the memory's address bus, its two chip selects (one active low, one active high), its active-low write strobe and its data bus in a fixed order. Every phase lasts long enough to meet the memory's minimum timing intervals, and the write lands in the memory when the strobe rises again.

Each interval is a parameter in nanoseconds. The block turns it into whole clock cycles by rounding up against the clock period parameter. The recovery phase is stretched when needed so that the whole cycle, measured from the first cycle the address is valid, reaches the minimum write cycle time. The host sees a one-cycle completion pulse. Only one write is in flight at a time.

Top module: `sram_wr_seq`

## Requirements
- R1: During and after reset the block is idle: `req_ready`=1, `mem_sel_n`=1, `mem_sel`=0, `mem_we_n`=1, `mem_dq_oe`=0, `wr_done`=0 and `mem_addr`=0. This also holds when reset is applied in the middle of a write.
- R2: `req_ready` is 1 only while idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are 1. A `req_valid` pulse that arrives while busy is ignored and has no effect on the pins.
- R3: `mem_addr` takes the accepted address in the cycle after acceptance and holds it unchanged until the completion pulse.
- R4: Both selects become active together after an address phase of A cycles, and they are active for at least one cycle before `mem_we_n` falls.
- R5: `mem_we_n` stays low for exactly L cycles, where L is the larger of the pulse-width and data-valid counts. `mem_dq_out` carries the accepted data from the cycle the strobe falls, and it does not change while the strobe is low.
- R6: The selects stay active until `mem_we_n` rises, for at least the select-to-end-of-write count in total, and they go inactive in the cycle the strobe rises.
- R7: `mem_dq_oe` is 1 from the cycle the strobe falls through hold and recovery, and it returns to 0 only in the completion cycle.
- R8: At least the recovery count of cycles passes between the strobe rising and completion. The number of cycles from the first cycle of valid address up to completion is at least the write cycle count, with the recovery phase stretched to reach it.
- R9: `wr_done` is high for exactly one cycle, and `req_ready` is 1 in the cycle that follows.
- R10: If `req_valid` is held high across a completion, the next request is accepted on the first idle cycle.
- R11: Each interval in cycles is ceil(ns / clock period), and an interval of 0 ns still takes one cycle.
- R12: The data on `mem_dq_out` at the rising edge of `mem_we_n` is what the memory stores at `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers a write |
| req_ready | output | 1 | Block is idle and can take a write |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| wr_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | DATA_W | Data driven onto the memory data bus |
| mem_dq_oe | output | 1 | Output enable for the data bus |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |

## Verification
The assertions assume that the host changes `req_addr` and `req_data` only through the handshake, and that reset is released only between clock edges. The stimulus drives every input on the falling clock edge and holds the address and data steady while `req_valid` is high and the block is idle. It raises `req_valid` while the block is busy only to show that such a request is ignored. It asserts reset in the middle of a write only at a falling edge, and the cycle-by-cycle comparison is suspended while reset is low.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ENABLE,
        PH_WE_LOW,
        PH_WE_HIGH,
        PH_RECOVER,
        PH_DONE
    } wr_phase_e;

    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned at_least_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned worst);
        return (worst < 2) ? 1 : $clog2(worst + 1);
    endfunction

    function automatic wr_phase_e phase_after(input wr_phase_e p);
        case (p)
            PH_IDLE:    return PH_ADDR;
            PH_ADDR:    return PH_ENABLE;
            PH_ENABLE:  return PH_WE_LOW;
            PH_WE_LOW:  return PH_WE_HIGH;
            PH_WE_HIGH: return PH_RECOVER;
            PH_RECOVER: return PH_DONE;
            default:    return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/sram_wr_dur.sv
module sram_wr_dur
    import sram_wr_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned T_CYCLE_NS    = 100,
    parameter int unsigned T_SEL_NS      = 80,
    parameter int unsigned T_SETUP_NS    = 0,
    parameter int unsigned T_PULSE_NS    = 60,
    parameter int unsigned T_DVALID_NS   = 40,
    parameter int unsigned T_HOLD_NS     = 0,
    parameter int unsigned T_RECOV_NS    = 5,
    parameter int unsigned CNT_W         = 8
) (
    input  wr_phase_e          phase_i,
    output logic [CNT_W-1:0]   load_o
);

    // Cycle counts for each phase, rounded up, never below one cycle.
    localparam int unsigned N_ADDR = at_least_one(ns_to_cyc(T_SETUP_NS, CLK_PERIOD_NS));
    localparam int unsigned N_LOW  = at_least_one(umax(ns_to_cyc(T_PULSE_NS, CLK_PERIOD_NS),
                                                       ns_to_cyc(T_DVALID_NS, CLK_PERIOD_NS)));
    localparam int unsigned N_SELC = ns_to_cyc(T_SEL_NS, CLK_PERIOD_NS);
    localparam int unsigned N_EN   = (N_SELC > N_LOW) ? (N_SELC - N_LOW) : 1;
    localparam int unsigned N_HOLD = at_least_one(ns_to_cyc(T_HOLD_NS, CLK_PERIOD_NS));
    localparam int unsigned N_PRE  = N_ADDR + N_EN + N_LOW + N_HOLD;
    localparam int unsigned N_WCYC = ns_to_cyc(T_CYCLE_NS, CLK_PERIOD_NS);
    localparam int unsigned N_STR  = (N_WCYC > N_PRE) ? (N_WCYC - N_PRE) : 0;
    localparam int unsigned N_REC  = at_least_one(umax(ns_to_cyc(T_RECOV_NS, CLK_PERIOD_NS), N_STR));

    // The counter is loaded with length minus one and counts down to zero.
    always_comb begin
        case (phase_i)
            PH_ADDR:    load_o = CNT_W'(N_ADDR - 1);
            PH_ENABLE:  load_o = CNT_W'(N_EN - 1);
            PH_WE_LOW:  load_o = CNT_W'(N_LOW - 1);
            PH_WE_HIGH: load_o = CNT_W'(N_HOLD - 1);
            PH_RECOVER: load_o = CNT_W'(N_REC - 1);
            default:    load_o = '0;
        endcase
    end

endmodule

// File: rtl/sram_wr_ctl.sv
module sram_wr_ctl
    import sram_wr_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_data_i,
    output logic              done_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_dq_out_o,
    output logic              mem_dq_oe_o,
    output logic              mem_sel_n_o,
    output logic              mem_sel_o,
    output logic              mem_we_n_o,
    output wr_phase_e         phase_succ_o,
    input  logic [CNT_W-1:0]  succ_load_i
);

    typedef struct packed {
        wr_phase_e          phase;
        logic [CNT_W-1:0]   cnt;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  data;
        logic               sel;
        logic               we_low;
        logic               oe;
        logic               done;
    } ctl_state_t;

    ctl_state_t s_d, s_q;
    logic       advance_d;

    assign phase_succ_o = phase_after(s_q.phase);

    always_comb begin
        s_d       = s_q;
        advance_d = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (req_valid_i) begin
                    s_d.addr  = req_addr_i;
                    s_d.data  = req_data_i;
                    advance_d = 1'b1;
                end
            end
            PH_DONE: advance_d = 1'b1;
            default: begin
                if (s_q.cnt == '0) begin
                    advance_d = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
        endcase
        if (advance_d) begin
            s_d.phase = phase_succ_o;
            s_d.cnt   = succ_load_i;
        end
        // Pin levels registered together with the phase they belong to.
        s_d.sel    = (s_d.phase == PH_ENABLE) || (s_d.phase == PH_WE_LOW);
        s_d.we_low = (s_d.phase == PH_WE_LOW);
        s_d.oe     = (s_d.phase == PH_WE_LOW) || (s_d.phase == PH_WE_HIGH) ||
                     (s_d.phase == PH_RECOVER);
        s_d.done   = (s_d.phase == PH_DONE);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{phase: PH_IDLE, cnt: '0, addr: '0, data: '0,
                     sel: 1'b0, we_low: 1'b0, oe: 1'b0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready_o  = (s_q.phase == PH_IDLE);
    assign done_o       = s_q.done;
    assign mem_addr_o   = s_q.addr;
    assign mem_dq_out_o = s_q.data;
    assign mem_dq_oe_o  = s_q.oe;
    assign mem_sel_n_o  = ~s_q.sel;
    assign mem_sel_o    = s_q.sel;
    assign mem_we_n_o   = ~s_q.we_low;

    AST_ACCEPT_LEAVES_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o) |=> !req_ready_o) else $error("accept did not leave idle"); // R2
    AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_ready_o |=> $stable(mem_addr_o)) else $error("address moved while busy"); // R3
    AST_SEL_BEFORE_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(mem_we_n_o) |-> $past(mem_sel_o)) else $error("strobe fell without prior select"); // R4
    AST_SEL_RISES_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mem_sel_o) |-> mem_we_n_o) else $error("select and strobe together"); // R4
    AST_DATA_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mem_we_n_o |=> $stable(mem_dq_out_o)) else $error("data moved under strobe"); // R5
    AST_SEL_DROPS_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mem_we_n_o) |-> !mem_sel_o) else $error("select outlived strobe"); // R6
    AST_OE_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mem_we_n_o) |-> mem_dq_oe_o) else $error("bus released at strobe rise"); // R7
    AST_OE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(mem_dq_oe_o) |-> done_o) else $error("bus released early"); // R7
    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> (!done_o && req_ready_o)) else $error("done not a single pulse"); // R9

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
    import sram_wr_pkg::*;
#(
    parameter int unsigned ADDR_W        = 16,
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned T_CYCLE_NS    = 100,
    parameter int unsigned T_SEL_NS      = 80,
    parameter int unsigned T_SETUP_NS    = 0,
    parameter int unsigned T_PULSE_NS    = 60,
    parameter int unsigned T_DVALID_NS   = 40,
    parameter int unsigned T_HOLD_NS     = 0,
    parameter int unsigned T_RECOV_NS    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              wr_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_we_n
);

    // Upper bound of any single phase length, used to size the down-counter.
    localparam int unsigned WORST = ns_to_cyc(T_CYCLE_NS, CLK_PERIOD_NS) +
                                    ns_to_cyc(T_SEL_NS, CLK_PERIOD_NS) +
                                    ns_to_cyc(T_SETUP_NS, CLK_PERIOD_NS) +
                                    ns_to_cyc(T_PULSE_NS, CLK_PERIOD_NS) +
                                    ns_to_cyc(T_DVALID_NS, CLK_PERIOD_NS) +
                                    ns_to_cyc(T_HOLD_NS, CLK_PERIOD_NS) +
                                    ns_to_cyc(T_RECOV_NS, CLK_PERIOD_NS) + 2;
    localparam int unsigned CNT_W = cnt_width(WORST);

    wr_phase_e        phase_succ;
    logic [CNT_W-1:0] succ_load;

    sram_wr_dur #(
        .CLK_PERIOD_NS (CLK_PERIOD_NS),
        .T_CYCLE_NS    (T_CYCLE_NS),
        .T_SEL_NS      (T_SEL_NS),
        .T_SETUP_NS    (T_SETUP_NS),
        .T_PULSE_NS    (T_PULSE_NS),
        .T_DVALID_NS   (T_DVALID_NS),
        .T_HOLD_NS     (T_HOLD_NS),
        .T_RECOV_NS    (T_RECOV_NS),
        .CNT_W         (CNT_W)
    ) dur_i (
        .phase_i (phase_succ),
        .load_o  (succ_load)
    );

    sram_wr_ctl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) ctl_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .req_valid_i  (req_valid),
        .req_ready_o  (req_ready),
        .req_addr_i   (req_addr),
        .req_data_i   (req_data),
        .done_o       (wr_done),
        .mem_addr_o   (mem_addr),
        .mem_dq_out_o (mem_dq_out),
        .mem_dq_oe_o  (mem_dq_oe),
        .mem_sel_n_o  (mem_sel_n),
        .mem_sel_o    (mem_sel),
        .mem_we_n_o   (mem_we_n),
        .phase_succ_o (phase_succ),
        .succ_load_i  (succ_load)
    );

endmodule

// File: tb/sram_wr_seq_tb_top.sv
`timescale 1ns/1ps
module sram_wr_seq_tb_top;

    localparam int CLK_NS = 5;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int T_CYC = 100, T_SEL = 80, T_SU = 0, T_PW = 60, T_DV = 40, T_DH = 0, T_RC = 5;

    function automatic int cdiv(input int ns);
        return (ns + CLK_NS - 1) / CLK_NS;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected phase lengths in cycles, worked out from the requirements.
    localparam int EA = imax(1, cdiv(T_SU));
    localparam int EL = imax(1, imax(cdiv(T_PW), cdiv(T_DV)));
    localparam int EE = imax(1, cdiv(T_SEL) - EL);
    localparam int EH = imax(1, cdiv(T_DH));
    localparam int ER = imax(1, imax(cdiv(T_RC), cdiv(T_CYC) - (EA + EE + EL + EH)));
    localparam int ET = EA + EE + EL + EH + ER;

    logic clk = 1'b0;
    logic rst_n;
    logic req_valid;
    logic req_ready;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_data;
    logic wr_done;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out;
    logic mem_dq_oe, mem_sel_n, mem_sel, mem_we_n;

    always #2.5 clk = ~clk;

    sram_wr_seq #(
        .ADDR_W (AW), .DATA_W (DW), .CLK_PERIOD_NS (CLK_NS),
        .T_CYCLE_NS (T_CYC), .T_SEL_NS (T_SEL), .T_SETUP_NS (T_SU),
        .T_PULSE_NS (T_PW), .T_DVALID_NS (T_DV), .T_HOLD_NS (T_DH), .T_RECOV_NS (T_RC)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .req_data (req_data), .wr_done (wr_done),
        .mem_addr (mem_addr), .mem_dq_out (mem_dq_out), .mem_dq_oe (mem_dq_oe),
        .mem_sel_n (mem_sel_n), .mem_sel (mem_sel), .mem_we_n (mem_we_n)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model: position within a write, 0 when idle.
    int m_t;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_data;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_t <= 0; m_addr <= '0; m_data <= '0;
        end else if (m_t == 0) begin
            if (req_valid) begin
                m_t <= 1; m_addr <= req_addr; m_data <= req_data;
            end
        end else if (m_t == ET + 1) begin
            m_t <= 0;
        end else begin
            m_t <= m_t + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic e_sel, e_we_low, e_oe;
            e_sel    = (m_t >= EA + 1) && (m_t <= EA + EE + EL);
            e_we_low = (m_t >= EA + EE + 1) && (m_t <= EA + EE + EL);
            e_oe     = (m_t >= EA + EE + 1) && (m_t <= ET);
            chk(req_ready == (m_t == 0), "R2", "req_ready", req_ready, m_t == 0);
            chk(mem_addr == m_addr, "R3", "mem_addr", mem_addr, m_addr);
            chk(mem_sel == e_sel && mem_sel_n == !e_sel, "R4", "selects", {mem_sel, mem_sel_n}, {e_sel, !e_sel});
            chk(mem_we_n == !e_we_low, "R5", "mem_we_n", mem_we_n, !e_we_low);
            chk(mem_dq_oe == e_oe, "R7", "mem_dq_oe", mem_dq_oe, e_oe);
            if (e_oe) chk(mem_dq_out == m_data, "R5", "mem_dq_out", mem_dq_out, m_data);
            chk(wr_done == (m_t == ET + 1), "R9", "wr_done", wr_done, m_t == ET + 1);
        end
    end

    // Behavioural memory with interval measurement in cycles of CLK_NS.
    logic [DW-1:0] mem [logic [AW-1:0]];
    int c_busy, c_sel, c_low, c_dat, c_rec;
    logic p_we, p_oe;
    logic [DW-1:0] p_dat;
    always @(negedge clk) begin
        if (!rst_n) begin
            c_busy = 0; c_sel = 0; c_low = 0; c_dat = 0; c_rec = 0;
            p_we = 1'b1; p_oe = 1'b0; p_dat = '0;
        end else if (!finished) begin
            if (!p_we && mem_we_n) begin
                mem[mem_addr] = mem_dq_out;
                chk(c_low * CLK_NS >= T_PW, "R5", "strobe width ns", c_low * CLK_NS, T_PW);
                chk(c_low == EL, "R11", "strobe cycles", c_low, EL);
                chk(c_sel * CLK_NS >= T_SEL, "R6", "select to end ns", c_sel * CLK_NS, T_SEL);
                chk(c_dat * CLK_NS >= T_DV, "R5", "data valid ns", c_dat * CLK_NS, T_DV);
                c_rec = 0;
            end
            if (wr_done) begin
                chk(c_rec * CLK_NS >= T_RC, "R8", "recovery ns", c_rec * CLK_NS, T_RC);
                chk(c_busy * CLK_NS >= T_CYC, "R8", "write cycle ns", c_busy * CLK_NS, T_CYC);
                chk(mem.exists(m_addr) && mem[m_addr] == m_data, "R12", "stored word",
                    mem.exists(m_addr) ? mem[m_addr] : 'x, m_data);
            end
            c_busy = req_ready ? 0 : c_busy + 1;
            c_sel  = mem_sel ? c_sel + 1 : 0;
            c_low  = !mem_we_n ? c_low + 1 : 0;
            c_dat  = (mem_dq_oe && p_oe && mem_dq_out == p_dat) ? c_dat + 1 : (mem_dq_oe ? 1 : 0);
            if (mem_we_n && !mem_sel && mem_dq_oe) c_rec = c_rec + 1;
            p_we = mem_we_n; p_oe = mem_dq_oe; p_dat = mem_dq_out;
        end
    end

    task automatic idle_pins(input string tag);
        chk(req_ready == 1'b1 && wr_done == 1'b0, tag, "ready/done", {req_ready, wr_done}, 2'b10);
        chk(mem_sel_n && !mem_sel && mem_we_n && !mem_dq_oe, tag, "pins",
            {mem_sel_n, mem_sel, mem_we_n, mem_dq_oe}, 4'b1010);
    endtask

    task automatic write_one(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_data = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!wr_done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_data = '0;
        repeat (3) @(negedge clk);
        idle_pins("R1");
        chk(mem_addr == '0, "R1", "addr at reset", mem_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        idle_pins("R1");

        write_one(16'h1234, 16'hA5A5);
        write_one(16'hFFFF, 16'h5A5A);
        write_one(16'h0000, 16'hFFFF);

        // Request during a busy write is ignored (R2).
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h0042; req_data = 16'h0F0F;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (6) @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h7777; req_data = 16'h1111;
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_addr == 16'h0042, "R2", "addr after busy request", mem_addr, 16'h0042);
        while (!wr_done) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R2", "no pending accept", req_ready, 1);

        // Valid held across completion: next request taken at once (R10).
        req_valid = 1'b1; req_addr = 16'h0100; req_data = 16'hC3C3;
        while (!wr_done) @(negedge clk);
        req_addr = 16'h0200; req_data = 16'h3C3C;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready after done", req_ready, 1);
        @(negedge clk);
        chk(req_ready == 1'b0, "R10", "accepted at once", req_ready, 0);
        chk(mem_addr == 16'h0200, "R10", "second address", mem_addr, 16'h0200);
        req_valid = 1'b0;
        while (!wr_done) @(negedge clk);
        @(negedge clk);

        // Reset in the middle of a write (R1).
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h0ABC; req_data = 16'h9999;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (EA + EE + 2) @(negedge clk);
        rst_n = 1'b0;
        #1;
        idle_pins("R1");
        chk(mem_addr == '0, "R1", "addr after mid reset", mem_addr, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        idle_pins("R1");

        write_one(16'h8001, 16'h0001);
        repeat (4) @(negedge clk);

        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule